// File: doc/BRIEF.md
# Extended IO interrupt router

This block collects 256 edge-type device interrupt lines for one node of four cores. Each line is captured into a pending bit that belongs to exactly one core. A per-vector route byte chooses that core, and a per-group pin map chooses which of the core's eight interrupt outputs the group raises. When a vector's bounce bit is set and its route names several cores, successive edges take turns among those cores. When the bounce bit is clear, the lowest named core is used.

Software sees the block through a simple 32-bit register port. A core select input tells the block which core's pending view a pending-register access refers to. Pending bits are read as 32-bit words and cleared by writing ones. Software changes a route by masking the vector, rewriting its route byte and unmasking it. A pending bit stays with the core that took it. A build parameter halves the vector count to 128, and the register space that is then unused reads as zero.

Top module: `eio_router`

## Requirements
- R1: After reset every register reads zero and every interrupt pin output is low.
- R2: The enable word at byte offset 0x1600+4*(v>>5) and the bounce word at 0x1680+4*(v>>5) hold vector v in bit v&31. Both are readable and writable. Route word 0x1C00+4*k holds vector 4k+b in bits [8b+7:8b]. Pin-map word 0x14C0+4*k holds group 4k+b in bits [8b+7:8b].
- R3: A low-to-high transition of dev_irq[v] while enable bit v is set sets exactly one pending bit for v. A level held high sets nothing further. A transition while the vector is disabled sets nothing.
- R4: The pending word at 0x1800+4*(v>>5), as seen with bus_core=c, shows core c's pending bit for v at bit v&31. Writing a one clears that bit for core c only. Writing a zero, or writing from another core select, leaves it unchanged. A new edge in the same cycle as a clear leaves the bit set.
- R5: Route byte bits [3:0] are a core map (bit c = core c). With the bounce bit clear, an edge goes to the lowest-numbered core in the map.
- R6: With the bounce bit set, successive edges go to the named cores in rising cyclic order. After reset the first bounced edge goes to the lowest named core.
- R7: A route byte whose bits [7:4] differ from the parameter LOCAL_NODE (default 0), or whose core map is empty, delivers to no core.
- R8: Pin-map byte g, for vectors 32g..32g+31, drives pin p of the target core when its bit p is set. Output irq_pin[8c+p] is core c's pin p. It rises one clock after the pending bit sets and falls one clock after the last pending-and-enabled bit of its groups is cleared or masked.
- R9: Control register 0x0000 bit 0 is a global enable. While it is 0 no pin rises, but pending bits still latch. Setting it raises the pins of already pending vectors one clock later.
- R10: Masking a pending vector, rewriting its route and unmasking it keeps the pending bit with its original core, and that core's pin returns.
- R11: With NUM_VEC=128, the enable words at 0x1610 and above, route words at 0x1C80 and above, pending words at 0x1810 and above, and pin-map word 0x14C4 read as zero, even after writes.
- R12: Read data is registered. bus_rdata changes in the clock after a read strobe, not in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_core | input | 2 | Core whose pending view the access uses |
| bus_rdata | output | 32 | Registered read data |
| dev_irq | input | NUM_VEC | Device interrupt lines, edge-type |
| irq_pin | output | 32 | Per-core interrupt pins, bit 8c+p |

## Verification
The bench sweeps every vector through its own core, group and pin. It checks the exact pin and the exact pending word bit, and that no other core sees the bit. A design that mixed up bit or byte lanes or core views would light the wrong output. Directed cases target the orderings that are easy to get wrong. A held-high line must not retrigger. A clear in the same cycle as a new edge must not lose the edge. A bounced vector must rotate in cyclic order from the lowest core after reset. A design that routed pending through the current route byte would move or lose an edge when the route is rewritten. A foreign node number must deliver nowhere. The halved build is read back to show that its unused words stay zero.

// File: rtl/eio_pkg.sv
package eio_pkg;
  localparam int CORE_N = 4;
  localparam int CORE_W = $clog2(CORE_N);
  localparam int PIN_N  = 8;
  localparam int NODE_W = 4;
  localparam int ADDR_W = 13;
  localparam int WA_W   = ADDR_W - 2;

  localparam logic [ADDR_W-1:0] CTRL_OFS  = 13'h0000;
  localparam logic [ADDR_W-1:0] PMAP_OFS  = 13'h14C0;
  localparam logic [ADDR_W-1:0] ENA_OFS   = 13'h1600;
  localparam logic [ADDR_W-1:0] BNC_OFS   = 13'h1680;
  localparam logic [ADDR_W-1:0] PEND_OFS  = 13'h1800;
  localparam logic [ADDR_W-1:0] ROUTE_OFS = 13'h1C00;

  localparam logic [WA_W-1:0] CTRL_WA  = CTRL_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] PMAP_WA  = PMAP_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ENA_WA   = ENA_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] BNC_WA   = BNC_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] PEND_WA  = PEND_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ROUTE_WA = ROUTE_OFS[ADDR_W-1:2];

  typedef logic [CORE_N-1:0] core_map_t;

  typedef struct packed {
    logic [NODE_W-1:0] node;
    core_map_t         cores;
  } route_t;

  // first core in map, searching upward from start and wrapping
  function automatic core_map_t pick_core(core_map_t map, logic [CORE_W-1:0] start);
    core_map_t sel;
    int        idx;
    sel = '0;
    for (int i = 0; i < CORE_N; i++) begin
      idx = (int'(start) + i) % CORE_N;
      if (sel == '0 && map[idx]) sel[idx] = 1'b1;
    end
    return sel;
  endfunction

  function automatic logic [CORE_W-1:0] onehot_idx(core_map_t m);
    logic [CORE_W-1:0] r;
    r = '0;
    for (int i = 0; i < CORE_N; i++) begin
      if (m[i]) r = CORE_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/eio_cfg.sv
module eio_cfg
  import eio_pkg::*;
#(
  parameter int NUM_VEC = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [WA_W-1:0]              waddr,
  input  logic [31:0]                  wdata,
  output logic                         gen_en_o,
  output logic [NUM_VEC-1:0]           ena_o,
  output logic [NUM_VEC-1:0]           bnc_o,
  output route_t [NUM_VEC-1:0]         route_o,
  output logic [NUM_VEC/32-1:0][PIN_N-1:0] pmap_o,
  output logic [NUM_VEC-1:0]           clr_o
);
  localparam int NGRP   = NUM_VEC / 32;
  localparam int RWORDS = NUM_VEC / 4;
  localparam int PWORDS = (NGRP + 3) / 4;

  logic                           gen_q, gen_d;
  logic [NUM_VEC-1:0]             ena_q, ena_d;
  logic [NUM_VEC-1:0]             bnc_q, bnc_d;
  route_t [NUM_VEC-1:0]           route_q, route_d;
  logic [NGRP-1:0][PIN_N-1:0]     pmap_q, pmap_d;

  always_comb begin
    gen_d   = gen_q;
    ena_d   = ena_q;
    bnc_d   = bnc_q;
    route_d = route_q;
    pmap_d  = pmap_q;
    clr_o   = '0;
    if (wr_en) begin
      if (waddr == CTRL_WA) gen_d = wdata[0];
      for (int w = 0; w < NGRP; w++) begin
        if (waddr == ENA_WA + WA_W'(w))  ena_d[w*32 +: 32] = wdata;
        if (waddr == BNC_WA + WA_W'(w))  bnc_d[w*32 +: 32] = wdata;
        if (waddr == PEND_WA + WA_W'(w)) clr_o[w*32 +: 32] = wdata;
      end
      for (int w = 0; w < RWORDS; w++) begin
        if (waddr == ROUTE_WA + WA_W'(w)) begin
          for (int b = 0; b < 4; b++) route_d[4*w+b] = route_t'(wdata[8*b +: 8]);
        end
      end
      for (int w = 0; w < PWORDS; w++) begin
        if (waddr == PMAP_WA + WA_W'(w)) begin
          for (int b = 0; b < 4; b++) pmap_d[4*w+b] = wdata[8*b +: PIN_N];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      ena_q   <= '0;
      bnc_q   <= '0;
      route_q <= '0;
      pmap_q  <= '0;
    end else if (wr_en) begin
      gen_q   <= gen_d;
      ena_q   <= ena_d;
      bnc_q   <= bnc_d;
      route_q <= route_d;
      pmap_q  <= pmap_d;
    end
  end

  assign gen_en_o = gen_q;
  assign ena_o    = ena_q;
  assign bnc_o    = bnc_q;
  assign route_o  = route_q;
  assign pmap_o   = pmap_q;
endmodule

// File: rtl/eio_steer.sv
module eio_steer
  import eio_pkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int LOCAL_NODE = 0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_VEC-1:0]               dev_irq,
  input  logic [NUM_VEC-1:0]               ena,
  input  logic [NUM_VEC-1:0]               bnc,
  input  route_t [NUM_VEC-1:0]             route,
  output logic [CORE_N-1:0][NUM_VEC-1:0]   set_o
);
  logic [NUM_VEC-1:0]             prev_q;
  logic [NUM_VEC-1:0][CORE_W-1:0] rr_q, rr_d;
  logic [NUM_VEC-1:0]             fire;

  assign fire = dev_irq & ~prev_q & ena;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    core_map_t tgt_map;
    core_map_t hit;
    assign tgt_map = (route[v].node == NODE_W'(LOCAL_NODE)) ? route[v].cores : '0;
    assign hit     = bnc[v] ? pick_core(tgt_map, rr_q[v] + 1'b1)
                            : pick_core(tgt_map, '0);
    assign rr_d[v] = (fire[v] && bnc[v] && hit != '0) ? onehot_idx(hit) : rr_q[v];
    for (genvar c = 0; c < CORE_N; c++) begin : g_core
      assign set_o[c][v] = fire[v] & hit[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      rr_q   <= '1;
    end else begin
      prev_q <= dev_irq;
      rr_q   <= rr_d;
    end
  end
endmodule

// File: rtl/eio_pend.sv
module eio_pend
  import eio_pkg::*;
#(
  parameter int NUM_VEC = 256
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_VEC-1:0]               set_i,
  input  logic [NUM_VEC-1:0]               clr_i,
  input  logic                             clr_sel,
  input  logic [NUM_VEC-1:0]               ena,
  input  logic [NUM_VEC/32-1:0][PIN_N-1:0] pmap,
  input  logic                             gen_en,
  output logic [NUM_VEC-1:0]               pend_o,
  output logic [PIN_N-1:0]                 pin_o
);
  localparam int NGRP = NUM_VEC / 32;

  logic [NUM_VEC-1:0] pend_q, pend_d;
  logic [PIN_N-1:0]   pin_q, pin_d;
  logic [NGRP-1:0]    grp_act;

  // a new edge wins over a clear in the same cycle
  assign pend_d = (pend_q & ~(clr_i & {NUM_VEC{clr_sel}})) | set_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_act[g] = |(pend_q[g*32 +: 32] & ena[g*32 +: 32]);
  end

  always_comb begin
    pin_d = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_act[g]) pin_d = pin_d | pmap[g];
    end
    pin_d = pin_d & {PIN_N{gen_en}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pin_q  <= '0;
    end else begin
      pend_q <= pend_d;
      pin_q  <= pin_d;
    end
  end

  assign pend_o = pend_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/eio_router.sv
module eio_router
  import eio_pkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int LOCAL_NODE = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic [CORE_W-1:0]         bus_core,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_VEC-1:0]        dev_irq,
  output logic [CORE_N*PIN_N-1:0]   irq_pin
);
  localparam int NGRP   = NUM_VEC / 32;
  localparam int RWORDS = NUM_VEC / 4;
  localparam int PWORDS = (NGRP + 3) / 4;

  logic [1:0]                    rst_sync_q;
  logic                          rst_sync_n;
  logic [WA_W-1:0]               waddr;
  logic                          wr_en;
  logic                          gen_en;
  logic [NUM_VEC-1:0]            ena, bnc, clr;
  route_t [NUM_VEC-1:0]          route;
  logic [NGRP-1:0][PIN_N-1:0]    pmap;
  logic [CORE_N-1:0][NUM_VEC-1:0] set_all, pend_all;
  logic [31:0]                   rd_mux, rdata_q;
  logic                          unused_lo;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign waddr     = bus_addr[ADDR_W-1:2];
  assign unused_lo = ^bus_addr[1:0];
  assign wr_en     = bus_sel & bus_we;

  eio_cfg #(.NUM_VEC(NUM_VEC)) cfg_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .waddr(waddr), .wdata(bus_wdata),
    .gen_en_o(gen_en), .ena_o(ena), .bnc_o(bnc), .route_o(route), .pmap_o(pmap),
    .clr_o(clr)
  );

  eio_steer #(.NUM_VEC(NUM_VEC), .LOCAL_NODE(LOCAL_NODE)) steer_i (
    .clk(clk), .rst_n(rst_sync_n), .dev_irq(dev_irq), .ena(ena), .bnc(bnc),
    .route(route), .set_o(set_all)
  );

  for (genvar c = 0; c < CORE_N; c++) begin : g_core
    eio_pend #(.NUM_VEC(NUM_VEC)) pend_i (
      .clk(clk), .rst_n(rst_sync_n), .set_i(set_all[c]), .clr_i(clr),
      .clr_sel(bus_core == CORE_W'(c)), .ena(ena), .pmap(pmap), .gen_en(gen_en),
      .pend_o(pend_all[c]), .pin_o(irq_pin[c*PIN_N +: PIN_N])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (waddr == CTRL_WA) rd_mux = {31'b0, gen_en};
    for (int w = 0; w < NGRP; w++) begin
      if (waddr == ENA_WA + WA_W'(w))  rd_mux = ena[w*32 +: 32];
      if (waddr == BNC_WA + WA_W'(w))  rd_mux = bnc[w*32 +: 32];
      if (waddr == PEND_WA + WA_W'(w)) rd_mux = pend_all[bus_core][w*32 +: 32];
    end
    for (int w = 0; w < RWORDS; w++) begin
      if (waddr == ROUTE_WA + WA_W'(w)) begin
        for (int b = 0; b < 4; b++) rd_mux[8*b +: 8] = route[4*w+b];
      end
    end
    for (int w = 0; w < PWORDS; w++) begin
      if (waddr == PMAP_WA + WA_W'(w)) begin
        for (int b = 0; b < 4; b++) rd_mux[8*b +: PIN_N] = pmap[4*w+b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)               rdata_q <= '0;
    else if (bus_sel && !bus_we)   rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/eio_router_chk.sv
module eio_router_chk
  import eio_pkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int LOCAL_NODE = 0
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_sel,
  input logic                             bus_we,
  input logic                             gen_en,
  input logic [NUM_VEC-1:0]               ena,
  input route_t [NUM_VEC-1:0]             route,
  input logic [CORE_N-1:0][NUM_VEC-1:0]   set_all,
  input logic [CORE_N-1:0][NUM_VEC-1:0]   pend_all,
  input logic [CORE_N*PIN_N-1:0]          irq_pin
);
  // R9
  gen_off_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !(bus_sel && bus_we)) |=> (irq_pin == '0));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [CORE_N-1:0] vset;
    for (genvar c = 0; c < CORE_N; c++) begin : g_bit
      assign vset[c] = set_all[c][v];
    end
    // R5
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vset));
    // R7
    node_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|vset) |-> (route[v].node == NODE_W'(LOCAL_NODE) && ena[v]));
  end

  for (genvar c = 0; c < CORE_N; c++) begin : g_core
    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we) |=> ((pend_all[c] & $past(pend_all[c])) == $past(pend_all[c])));
    // R8
    pin_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|irq_pin[c*PIN_N +: PIN_N]) |-> $past(|(pend_all[c] & ena)));
  end
endmodule

bind eio_router eio_router_chk #(.NUM_VEC(NUM_VEC), .LOCAL_NODE(LOCAL_NODE)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we), .gen_en(gen_en),
  .ena(ena), .route(route), .set_all(set_all), .pend_all(pend_all), .irq_pin(irq_pin)
);

// File: tb/eio_router_tb.sv
`timescale 1ns/1ps
module eio_router_tb_top;
  logic        clk, rst_n;
  logic        bus_sel, bus_we;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  bus_core;
  logic [31:0] rdata, rdata_h;
  logic [255:0] dev_irq;
  logic [31:0] irq_pin, irq_pin_h;
  int n_chk = 0;
  int n_bad = 0;

  eio_router #(.NUM_VEC(256), .LOCAL_NODE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_core(bus_core), .bus_rdata(rdata), .dev_irq(dev_irq),
    .irq_pin(irq_pin));

  eio_router #(.NUM_VEC(128), .LOCAL_NODE(0)) dut_h (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_core(bus_core), .bus_rdata(rdata_h), .dev_irq(128'b0),
    .irq_pin(irq_pin_h));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [1:0] c);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_core = c;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [1:0] c, output logic [31:0] d,
                    output logic [31:0] dh);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_core = c;
    @(negedge clk);
    bus_sel = 1'b0;
    d = rdata; dh = rdata_h;
  endtask

  task automatic pulse(input int v);
    @(negedge clk); dev_irq[v] = 1'b1;
    @(negedge clk); dev_irq[v] = 1'b0;
  endtask

  function automatic int next_core(input logic [3:0] map, input int prev);
    int r;
    r = -1;
    for (int i = 1; i <= 4; i++) begin
      if (r < 0 && map[(prev + i) % 4]) r = (prev + i) % 4;
    end
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, dh;
    int prev;
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; bus_core = '0;
    dev_irq = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pins", irq_pin, 32'h0);
    rd(13'h0000, 0, d, dh); check("R1 ctrl", d, 0);
    rd(13'h1600, 0, d, dh); check("R1 enable", d, 0);
    rd(13'h1C00, 0, d, dh); check("R1 route", d, 0);
    rd(13'h14C0, 0, d, dh); check("R1 pinmap", d, 0);
    rd(13'h1800, 2, d, dh); check("R1 pending", d, 0);

    // configuration: core = v%4, group g -> pin g, all enabled
    wr(13'h0000, 32'h1, 0);
    wr(13'h14C0, 32'h08040201, 0);
    wr(13'h14C4, 32'h80402010, 0);
    for (int w = 0; w < 8; w++) wr(13'h1600 + 13'(4*w), 32'hFFFFFFFF, 0);
    for (int w = 0; w < 64; w++) wr(13'h1C00 + 13'(4*w), 32'h08040201, 0);

    // R2 readback
    rd(13'h1CFC, 0, d, dh); check("R2 route word", d, 32'h08040201);
    rd(13'h14C4, 0, d, dh); check("R2 pinmap word", d, 32'h80402010);
    wr(13'h160C, 32'hA5A50F0F, 0);
    rd(13'h160C, 0, d, dh); check("R2 enable word", d, 32'hA5A50F0F);
    wr(13'h160C, 32'hFFFFFFFF, 0);
    wr(13'h169C, 32'h12345678, 0);
    rd(13'h169C, 0, d, dh); check("R2 bounce word", d, 32'h12345678);
    wr(13'h169C, 32'h0, 0);

    // R12 registered read data
    rd(13'h1C00, 0, d, dh);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = 13'h0000;
    #1 check("R12 held in strobe cycle", rdata, 32'h08040201);
    @(negedge clk); bus_sel = 0;
    check("R12 updated after edge", rdata, 32'h1);

    // R3 R4 R5 R8 sweep over every vector
    for (int v = 0; v < 256; v++) begin
      int c, g;
      c = v % 4; g = v / 32;
      pulse(v);
      check("R8 pin not early", irq_pin, 32'h0);
      @(negedge clk);
      check("R8 R5 pin", irq_pin, 32'h1 << (c*8 + g));
      rd(13'h1800 + 13'(4*g), 2'(c), d, dh); check("R3 R4 pending", d, 32'h1 << (v % 32));
      rd(13'h1800 + 13'(4*g), 2'((c+1)%4), d, dh); check("R4 other core", d, 32'h0);
      wr(13'h1800 + 13'(4*g), 32'h1 << (v % 32), 2'(c));
      rd(13'h1800 + 13'(4*g), 2'(c), d, dh); check("R4 cleared", d, 32'h0);
      check("R8 pin falls", irq_pin, 32'h0);
    end

    // R3 level held high sets only once
    @(negedge clk); dev_irq[7] = 1'b1;
    repeat (3) @(negedge clk);
    wr(13'h1800, 32'h80, 3);
    rd(13'h1800, 3, d, dh); check("R3 level no retrigger", d, 32'h0);
    dev_irq[7] = 1'b0;
    @(negedge clk); check("R3 level pin", irq_pin, 32'h0);

    // R3 disabled vector
    wr(13'h1600, ~32'h200, 0);
    pulse(9); @(negedge clk);
    check("R3 disabled pin", irq_pin, 32'h0);
    rd(13'h1800, 1, d, dh); check("R3 disabled pending", d, 32'h0);
    wr(13'h1600, 32'hFFFFFFFF, 0);
    rd(13'h1800, 1, d, dh); check("R3 no late set", d, 32'h0);

    // R4 zero write, other core, set wins over clear
    pulse(5);
    wr(13'h1800, 32'h0, 1);
    rd(13'h1800, 1, d, dh); check("R4 zero write", d, 32'h20);
    wr(13'h1800, 32'h20, 0);
    rd(13'h1800, 1, d, dh); check("R4 other core clear", d, 32'h20);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 13'h1800; bus_wdata = 32'h20; bus_core = 1;
    dev_irq[5] = 1'b1;
    @(negedge clk); bus_sel = 0; bus_we = 0; dev_irq[5] = 1'b0;
    rd(13'h1800, 1, d, dh); check("R4 set wins", d, 32'h20);
    wr(13'h1800, 32'h20, 1);
    rd(13'h1800, 1, d, dh); check("R4 final clear", d, 32'h0);

    // R9 global enable
    wr(13'h0000, 32'h0, 0);
    pulse(2); @(negedge clk); @(negedge clk);
    check("R9 pin held low", irq_pin, 32'h0);
    rd(13'h1800, 2, d, dh); check("R9 pending latched", d, 32'h4);
    rd(13'h0000, 0, d, dh); check("R9 ctrl", d, 32'h0);
    wr(13'h0000, 32'h1, 0);
    @(negedge clk); check("R9 pin after enable", irq_pin, 32'h1 << 16);
    wr(13'h1800, 32'h4, 2);

    // R7 foreign node and empty map
    wr(13'h1C00, 32'h11040200, 0);
    pulse(0); pulse(3); @(negedge clk); @(negedge clk);
    check("R7 pins", irq_pin, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(13'h1800, 2'(c), d, dh); check("R7 pending", d, 32'h0);
    end
    wr(13'h1C00, 32'h08040201, 0);

    // R6 bounce rotation on vector 40, map cores 0,2,3
    wr(13'h1C28, 32'h0804020D, 0);
    wr(13'h1684, 32'h100, 0);
    rd(13'h1684, 0, d, dh); check("R2 bounce readback", d, 32'h100);
    prev = 3;
    for (int i = 0; i < 6; i++) begin
      int ec;
      ec = next_core(4'hD, prev);
      pulse(40); @(negedge clk);
      check("R6 rotation", irq_pin, 32'h1 << (ec*8 + 1));
      wr(13'h1804, 32'h100, 2'(ec));
      prev = ec;
    end
    wr(13'h1684, 32'h0, 0);
    wr(13'h1C28, 32'h0804020C, 0);
    pulse(40); @(negedge clk);
    check("R5 lowest core", irq_pin, 32'h1 << (2*8 + 1));
    wr(13'h1804, 32'h100, 2);
    wr(13'h1C28, 32'h08040201, 0);

    // R10 route change keeps pending
    pulse(50); @(negedge clk);
    check("R10 pin before", irq_pin, 32'h1 << 17);
    wr(13'h1604, ~32'h40000, 0);
    @(negedge clk); check("R8 masked pin", irq_pin, 32'h0);
    wr(13'h1C30, 32'h08010201, 0);
    wr(13'h1604, 32'hFFFFFFFF, 0);
    rd(13'h1800 + 13'h4, 2, d, dh); check("R10 pending kept", d, 32'h40000);
    check("R10 pin back", irq_pin, 32'h1 << 17);
    rd(13'h1804, 0, d, dh); check("R10 not moved", d, 32'h0);
    wr(13'h1804, 32'h40000, 2);
    wr(13'h1C30, 32'h08040201, 0);

    // R11 halved build
    rd(13'h1600, 0, d, dh); check("R11 low enable", dh, 32'hFFFFFFFF);
    rd(13'h1614, 0, d, dh);
    check("R11 high enable", dh, 32'h0);
    check("R11 full build enable", d, 32'hFFFFFFFF);
    rd(13'h1CA0, 0, d, dh); check("R11 high route", dh, 32'h0);
    rd(13'h14C4, 0, d, dh); check("R11 pinmap", dh, 32'h0);
    rd(13'h1810, 0, d, dh); check("R11 pending", dh, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule